// File: doc/BRIEF.md
# Wake-Up Event Flag Unit

The block catches three wake-up events that arrive from an always-on domain and holds each in a sticky flag until software clears it. The three events are a software-triggered event, a compare match from a real-time-counter channel, and a programmable wake-up source whose kind is given by a source-type code. Any raised flag drives a single wake-up output.

Software reads the flags through a small register port and clears them through a separate clear register. Clearing works as a level handshake. Software sets a clear bit and keeps it set until the matching flag reads 0. While a clear bit is held it overrides new events for its flag. Whether a clear reaches the programmable flag depends on the source type:

- The programmable flag's own clear bit works only when the source is an I/O event.
- The compare clear bit also drops the programmable flag when the compare channel is the selected source.

Each clear bit passes through a two-stage synchronizer before it acts on a flag.

Top module: `wuf_top`

## Requirements
- R1: After reset, every flag and every clear bit is 0. The flags register, the clear register and `wake_o` all read 0.
- R2: The flag positions are fixed: bit 0 is the programmable source, bit 1 is the software event and bit 2 is the compare event. An event input that is sampled high at a rising edge sets its flag after that edge. The flag stays set after the input drops.
- R3: The compare flag sets on a compare event whatever the value of `prog_src_i`.
- R4: Writing 1 to a clear bit drops its flag after the third rising edge following the write edge. The flag still reads 1 after the first and second edges.
- R5: While a synchronized clear bit is active, an event for that flag does not set it. After the clear bit is written back to 0 at edge n, an event sampled at edge n+1 or n+2 is still blocked, and an event sampled at edge n+3 sets the flag.
- R6: The compare clear (bit 2) also clears the programmable flag when `prog_src_i` is 2'b01 (compare channel). With any other source type it leaves the programmable flag alone.
- R7: The programmable clear (bit 0) clears the programmable flag only when `prog_src_i` is 2'b00 (I/O event). With 2'b01 or 2'b10 that flag stays set.
- R8: The register map uses byte offsets: 0x0 is the flags register and 0x4 is the clear register. Writes to 0x0 have no effect. Bits 31:3 of both registers and any other offset read 0, and write data in bits 31:3 is dropped.
- R9: `wake_o` is 1 exactly when at least one flag is 1, in the same cycle.
- R10: Reading the clear register returns the clear bits last written in bits 2:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ev_cmp_i | input | 1 | Compare event from the real-time counter |
| ev_sw_i | input | 1 | Software-triggered event |
| ev_prog_i | input | 1 | Programmable wake-up event |
| prog_src_i | input | 2 | Source type of the programmable event: 00 I/O, 01 compare channel, 10/11 other |
| bus_sel_i | input | 1 | Register access strobe |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 4 | Byte offset |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational, valid during a read |
| wake_o | output | 1 | OR of all flags |

## Verification
The assertions assume that the event inputs and `prog_src_i` only change between clock edges, so each can be sampled cleanly at an edge. They also assume that `wake_o` is compared with read data only while the flags offset is on the bus. The stimulus drives every input on the falling edge and keeps each clear bit set for at least three cycles before releasing it, so the handshake rule always holds. The source-type code changes only while no synchronized clear is in flight, except where the test deliberately looks at a clear that is already held.

// File: rtl/wuf_pkg.sv
// Package: shared constants and types for the wake-up event flag unit.
// Assumes a fixed set of three event sources at fixed flag positions.
package wuf_pkg;

    localparam int NUM_EV   = 3;
    localparam int IDX_PROG = 0;
    localparam int IDX_SW   = 1;
    localparam int IDX_CMP  = 2;

    localparam logic [3:0] OFS_FLAGS = 4'h0;
    localparam logic [3:0] OFS_CLEAR = 4'h4;

    typedef enum logic [1:0] {
        SRC_IO    = 2'b00,
        SRC_CMP   = 2'b01,
        SRC_OTHER = 2'b10,
        SRC_RSVD  = 2'b11
    } prog_src_e;

endpackage

// File: rtl/wuf_regif.sv
// Register port: decodes reads and writes, and holds the clear bits.
// Assumes single-cycle accesses. Reads are combinational from current state.
module wuf_regif
    import wuf_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel_i,
    input  logic              bus_wr_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    input  logic [NUM_EV-1:0] flags_i,
    output logic [NUM_EV-1:0] clr_o,
    output logic [DATA_W-1:0] bus_rdata_o
);

    localparam logic [ADDR_W-1:0] A_FLAGS = ADDR_W'(OFS_FLAGS);
    localparam logic [ADDR_W-1:0] A_CLEAR = ADDR_W'(OFS_CLEAR);

    logic              wr_clear;
    logic              rd_en;
    logic [NUM_EV-1:0] clr_q;

    // Write strobe for the clear register. The flags register ignores writes.
    always_comb begin
        wr_clear = bus_sel_i && bus_wr_i && (bus_addr_i == A_CLEAR);
        rd_en    = bus_sel_i && !bus_wr_i;
    end

    // Clear-bit storage. Only the low bits of the write data are kept.
    always_ff @(posedge clk) begin
        if (!rst_n)
            clr_q <= '0;
        else if (wr_clear)
            clr_q <= bus_wdata_i[NUM_EV-1:0];
    end

    // Read mux. Upper bits and unmapped offsets return zero.
    always_comb begin
        bus_rdata_o = '0;
        if (rd_en) begin
            if (bus_addr_i == A_FLAGS)
                bus_rdata_o[NUM_EV-1:0] = flags_i;
            else if (bus_addr_i == A_CLEAR)
                bus_rdata_o[NUM_EV-1:0] = clr_q;
        end
    end

    assign clr_o = clr_q;

endmodule

// File: rtl/wuf_sync.sv
// Multi-stage synchronizer for a vector of level signals.
// Assumes the inputs are levels that stay stable for longer than STAGES cycles.
module wuf_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [STAGES-1:0][WIDTH-1:0] stage_q;

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // First stage captures the raw level.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[0] <= '0;
                    else        stage_q[0] <= d_i;
                end
            end else begin : g_next
                // Later stages pass the value along.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/wuf_flag_bank.sv
// Sticky flag bank: each flag sets on its event and drops under its effective clear.
// Routes the clears to the programmable flag according to its source type.
// Assumes the clears are already synchronized. A clear has priority over an event.
module wuf_flag_bank
    import wuf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_EV-1:0] ev_i,
    input  logic [NUM_EV-1:0] clr_sync_i,
    input  logic [1:0]        prog_src_i,
    output logic [NUM_EV-1:0] flags_o
);

    logic [NUM_EV-1:0] eff_clr;
    prog_src_e         src;

    // Per-flag effective clear, with the source routing for the programmable flag.
    always_comb begin
        src               = prog_src_e'(prog_src_i);
        eff_clr           = '0;
        eff_clr[IDX_SW]   = clr_sync_i[IDX_SW];
        eff_clr[IDX_CMP]  = clr_sync_i[IDX_CMP];
        eff_clr[IDX_PROG] = (clr_sync_i[IDX_PROG] && (src == SRC_IO)) ||
                            (clr_sync_i[IDX_CMP]  && (src == SRC_CMP));
    end

    genvar i;
    generate
        for (i = 0; i < NUM_EV; i++) begin : g_flag
            // One sticky flag: the clear wins, otherwise an event sets it.
            always_ff @(posedge clk) begin
                if (!rst_n)          flags_o[i] <= 1'b0;
                else if (eff_clr[i]) flags_o[i] <= 1'b0;
                else if (ev_i[i])    flags_o[i] <= 1'b1;
            end
        end
    endgenerate

endmodule

// File: rtl/wuf_top.sv
// Top level of the wake-up event flag unit: register port, clear synchronizer, flag bank.
// Assumes the event inputs are already in this clock domain.
module wuf_top
    import wuf_pkg::*;
#(
    parameter int ADDR_W      = 4,
    parameter int DATA_W      = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_cmp_i,
    input  logic              ev_sw_i,
    input  logic              ev_prog_i,
    input  logic [1:0]        prog_src_i,
    input  logic              bus_sel_i,
    input  logic              bus_wr_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic              wake_o
);

    logic [NUM_EV-1:0] flag_q;
    logic [NUM_EV-1:0] clr_q;
    logic [NUM_EV-1:0] clr_sync;
    logic [NUM_EV-1:0] ev_vec;

    // Place the event inputs at their fixed flag positions.
    always_comb begin
        ev_vec           = '0;
        ev_vec[IDX_PROG] = ev_prog_i;
        ev_vec[IDX_SW]   = ev_sw_i;
        ev_vec[IDX_CMP]  = ev_cmp_i;
    end

    wuf_regif #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regif (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_sel_i   (bus_sel_i),
        .bus_wr_i    (bus_wr_i),
        .bus_addr_i  (bus_addr_i),
        .bus_wdata_i (bus_wdata_i),
        .flags_i     (flag_q),
        .clr_o       (clr_q),
        .bus_rdata_o (bus_rdata_o)
    );

    wuf_sync #(.WIDTH(NUM_EV), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (clr_q),
        .q_o   (clr_sync)
    );

    wuf_flag_bank u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .ev_i       (ev_vec),
        .clr_sync_i (clr_sync),
        .prog_src_i (prog_src_i),
        .flags_o    (flag_q)
    );

    // Wake-up request whenever any flag is pending.
    assign wake_o = |flag_q;

endmodule

// File: rtl/wuf_chk.sv
// Checker for wuf_top: timing relations between events, clears, flags and the read port.
// Assumes the default two-stage synchronizer.
module wuf_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        ev_cmp_i,
    input logic        ev_sw_i,
    input logic        bus_sel_i,
    input logic        bus_wr_i,
    input logic [3:0]  bus_addr_i,
    input logic [31:0] bus_rdata_o,
    input logic        wake_o,
    input logic [2:0]  flag_q,
    input logic [2:0]  clr_q
);

    // R2
    sw_rise_needs_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q[1]) |-> $past(ev_sw_i));

    // R3
    cmp_rise_needs_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q[2]) |-> $past(ev_cmp_i));

    // R4
    sw_fall_needs_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag_q[1]) |-> $past(clr_q[1], 3));

    // R6
    cmp_fall_needs_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag_q[2]) |-> $past(clr_q[2], 3));

    // R7
    prog_fall_needs_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag_q[0]) |-> ($past(clr_q[0], 3) || $past(clr_q[2], 3)));

    // R8
    upper_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata_o[31:3] == 29'd0);

    // R9
    wake_matches_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel_i && !bus_wr_i && bus_addr_i == 4'h0) |-> (wake_o == (|bus_rdata_o[2:0])));

endmodule

bind wuf_top wuf_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ev_cmp_i    (ev_cmp_i),
    .ev_sw_i     (ev_sw_i),
    .bus_sel_i   (bus_sel_i),
    .bus_wr_i    (bus_wr_i),
    .bus_addr_i  (bus_addr_i),
    .bus_rdata_o (bus_rdata_o),
    .wake_o      (wake_o),
    .flag_q      (flag_q),
    .clr_q       (clr_q)
);

// File: tb/wuf_top_bench.sv
`timescale 1ns/1ps
// Scoreboard bench: driver tasks push expected values, a monitor pops and compares them.
module wuf_top_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ev_cmp_i = 1'b0, ev_sw_i = 1'b0, ev_prog_i = 1'b0;
    logic [1:0]  prog_src_i = 2'b10;
    logic        bus_sel_i = 1'b0, bus_wr_i = 1'b0;
    logic [3:0]  bus_addr_i = 4'h0;
    logic [31:0] bus_wdata_i = '0;
    logic [31:0] bus_rdata_o;
    logic        wake_o;

    typedef struct {
        bit          is_wake;
        logic [31:0] exp;
        string       req;
    } item_t;

    item_t q[$];
    int    n_checks = 0;
    int    n_fail = 0;
    bit    done = 1'b0;

    always #2.5 clk = ~clk;

    wuf_top u_wuf_top (
        .clk(clk), .rst_n(rst_n), .ev_cmp_i(ev_cmp_i), .ev_sw_i(ev_sw_i),
        .ev_prog_i(ev_prog_i), .prog_src_i(prog_src_i), .bus_sel_i(bus_sel_i),
        .bus_wr_i(bus_wr_i), .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i),
        .bus_rdata_o(bus_rdata_o), .wake_o(wake_o)
    );

    // Monitor: compares queued expectations shortly after each falling edge.
    always @(negedge clk) begin
        #1;
        while (q.size() > 0) begin
            item_t it;
            logic [31:0] got;
            it  = q.pop_front();
            got = it.is_wake ? {31'd0, wake_o} : bus_rdata_o;
            n_checks++;
            if (got !== it.exp) begin
                n_fail++;
                $display("FAIL %s: got %h expected %h", it.req, got, it.exp);
            end
        end
    end

    task automatic rd_check(input logic [3:0] a, input logic [31:0] e, input string r);
        @(negedge clk);
        bus_sel_i = 1'b1; bus_wr_i = 1'b0; bus_addr_i = a;
        q.push_back('{is_wake: 1'b0, exp: e, req: r});
    endtask

    task automatic wake_check(input logic e, input string r);
        @(negedge clk);
        q.push_back('{is_wake: 1'b1, exp: {31'd0, e}, req: r});
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel_i = 1'b1; bus_wr_i = 1'b1; bus_addr_i = a; bus_wdata_i = d;
        @(negedge clk);
        bus_sel_i = 1'b0; bus_wr_i = 1'b0;
    endtask

    task automatic pulse(input int which);
        @(negedge clk);
        if (which == 0) ev_prog_i = 1'b1;
        if (which == 1) ev_sw_i   = 1'b1;
        if (which == 2) ev_cmp_i  = 1'b1;
        @(negedge clk);
        ev_prog_i = 1'b0; ev_sw_i = 1'b0; ev_cmp_i = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd_check(4'h0, 32'h0, "R1 flags");
        rd_check(4'h4, 32'h0, "R1 clear");
        wake_check(1'b0, "R1 wake");
        // R2 software event sets bit 1 and sticks
        pulse(1);
        rd_check(4'h0, 32'h2, "R2 sw flag");
        idle(3);
        rd_check(4'h0, 32'h2, "R2 sticky");
        wake_check(1'b1, "R9 wake on one flag");
        // R3 compare sets whatever the source type; R2 prog at bit 0
        prog_src_i = 2'b10;
        pulse(2);
        rd_check(4'h0, 32'h6, "R3 cmp flag");
        pulse(0);
        rd_check(4'h0, 32'h7, "R2 prog flag");
        // R8 flags register ignores writes, upper clear bits dropped
        wr(4'h0, 32'h0);
        rd_check(4'h0, 32'h7, "R8 flags write ignored");
        wr(4'h4, 32'hFFFF_FFF8);
        rd_check(4'h4, 32'h0, "R8 clear upper bits");
        rd_check(4'h8, 32'h0, "R8 unmapped offset");
        idle(3);
        rd_check(4'h0, 32'h7, "R8 flags unchanged");
        // R4 exact clear latency
        wr(4'h4, 32'h2);
        rd_check(4'h0, 32'h7, "R4 edge+1");
        rd_check(4'h0, 32'h7, "R4 edge+2");
        rd_check(4'h0, 32'h5, "R4 edge+3");
        rd_check(4'h4, 32'h2, "R10 clear readback");
        // R5 event blocked while clear held, then re-arm timing
        pulse(1);
        rd_check(4'h0, 32'h5, "R5 blocked while held");
        wr(4'h4, 32'h0);
        ev_sw_i = 1'b1;
        rd_check(4'h0, 32'h5, "R5 release+1");
        rd_check(4'h0, 32'h5, "R5 release+2");
        rd_check(4'h0, 32'h7, "R5 release+3");
        ev_sw_i = 1'b0;
        // R7 prog clear only for I/O source
        prog_src_i = 2'b10;
        wr(4'h4, 32'h1);
        idle(4);
        rd_check(4'h0, 32'h7, "R7 other source");
        prog_src_i = 2'b01;
        idle(2);
        rd_check(4'h0, 32'h7, "R7 compare source");
        prog_src_i = 2'b00;
        idle(1);
        rd_check(4'h0, 32'h6, "R7 io source");
        wr(4'h4, 32'h0);
        idle(4);
        // R6 compare clear also drops prog when compare is the source
        pulse(0);
        rd_check(4'h0, 32'h7, "R6 setup");
        prog_src_i = 2'b01;
        wr(4'h4, 32'h4);
        idle(4);
        rd_check(4'h0, 32'h2, "R6 both cleared");
        wr(4'h4, 32'h0);
        idle(4);
        prog_src_i = 2'b00;
        pulse(0);
        pulse(2);
        wr(4'h4, 32'h4);
        idle(4);
        rd_check(4'h0, 32'h3, "R6 prog kept for io");
        // R9 clear all, wake drops
        wr(4'h4, 32'h7);
        idle(4);
        rd_check(4'h0, 32'h0, "R9 all clear");
        wake_check(1'b0, "R9 wake low");
        rd_check(4'h4, 32'h7, "R10 all bits");
        idle(2);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #100000;
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule